// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block forms the effective address of a fixed-point load or store and decides whether the base register gets the new address written back. Each request presents an addressing form (displacement, word-scaled displacement, quad-scaled displacement or register-indexed), an update flag, a load/store flag, the base and target register numbers, the base and index register values and the immediate field. One cycle later the unit presents the 64-bit address, a write-back enable with its register number and data, and a flag that marks an illegal operand combination.

Register file reads, memory access, alignment checks and translation happen elsewhere. The register values arrive as plain ports. The immediate always enters right-aligned on `imm_i`. The displacement form uses all 16 bits. The word-scaled form uses bits [13:0]. The quad-scaled form uses bits [11:0].

Top module: `ls_ea_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `valid_o`, `ea_o`, `wb_en_o`, `wb_idx_o`, `wb_data_o` and `invalid_o` are all zero.
- R2: With `form_i`=0 (displacement), the address is base plus `imm_i[15:0]` sign-extended to 64 bits.
- R3: With `form_i`=1 (word-scaled), the address is base plus the value of `imm_i[13:0]` followed by two zero bits, sign-extended from bit 15.
- R4: With `form_i`=2 (quad-scaled), the address is base plus the value of `imm_i[11:0]` followed by four zero bits, sign-extended from bit 15.
- R5: With `form_i`=3 (indexed), the address is base plus `rb_val_i`.
- R6: For a request without update, the base is zero when `ra_i` is 0 and `ra_val_i` otherwise.
- R7: For a request with update, the base is always `ra_val_i`, including when `ra_i` is 0.
- R8: A load with update (`is_store_i`=0) with `ra_i`=0 or `ra_i`=`rt_i` raises `invalid_o` and keeps `wb_en_o` low.
- R9: A store with update with `ra_i`=0 raises `invalid_o` and keeps `wb_en_o` low. When `ra_i` equals the source register `rt_i` it is legal and writes back.
- R10: A legal update request raises `wb_en_o` with `wb_idx_o`=`ra_i` and `wb_data_o` equal to the address. A request without update never raises `wb_en_o` or `invalid_o`.
- R11: Address addition wraps modulo 2^64.
- R12: Outputs appear on the first clock edge after `valid_i` is sampled high, with `valid_o` high for exactly that cycle. In a cycle without a request, `wb_en_o` and `invalid_o` are low and `ea_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| form_i | input | 2 | Addressing form: 0 displacement, 1 word-scaled, 2 quad-scaled, 3 indexed |
| update_i | input | 1 | Update form: write the address back to the base register |
| is_store_i | input | 1 | 1 for a store, 0 for a load |
| ra_i | input | 5 | Base register number |
| rt_i | input | 5 | Target (load) or source (store) register number |
| ra_val_i | input | 64 | Base register value |
| rb_val_i | input | 64 | Index register value |
| imm_i | input | 16 | Immediate field, right-aligned |
| valid_o | output | 1 | Result valid |
| ea_o | output | 64 | Effective address |
| wb_en_o | output | 1 | Base register write-back enable |
| wb_idx_o | output | 5 | Base register number to write |
| wb_data_o | output | 64 | Value to write (the address) |
| invalid_o | output | 1 | Illegal operand combination for the update form |

## Verification
The bench builds the unit with its default widths: a 64-bit address, 5-bit register numbers and a 16-bit immediate. At these widths, base values near 2^64 together with negative displacements reach the wrap-around path. The 5-bit register fields make collisions between base, target and register 0 frequent under random stimulus. Directed cases pin each scaled immediate at its most negative and most positive value, and every invalid pairing for both loads and stores.

// File: rtl/ls_ea_pkg.sv
package ls_ea_pkg;
  typedef enum logic [1:0] {
    FORM_DISP  = 2'd0,
    FORM_WDISP = 2'd1,
    FORM_QDISP = 2'd2,
    FORM_INDEX = 2'd3
  } ea_form_e;
endpackage

// File: rtl/ls_ea_offset.sv
module ls_ea_offset
  import ls_ea_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16,
  parameter int WS_W  = 14,
  parameter int QS_W  = 12
) (
  input  ea_form_e          form_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [XLEN-1:0]   idx_val_i,
  output logic [XLEN-1:0]   offset_o
);
  localparam int WS_SH = 2;
  localparam int QS_SH = 4;

  logic [XLEN-1:0] disp_ext, ws_ext, qs_ext;

  assign disp_ext = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign ws_ext   = {{(XLEN-WS_W-WS_SH){imm_i[WS_W-1]}}, imm_i[WS_W-1:0], {WS_SH{1'b0}}};
  assign qs_ext   = {{(XLEN-QS_W-QS_SH){imm_i[QS_W-1]}}, imm_i[QS_W-1:0], {QS_SH{1'b0}}};

  always_comb begin
    unique case (form_i)
      FORM_DISP:  offset_o = disp_ext;
      FORM_WDISP: offset_o = ws_ext;
      FORM_QDISP: offset_o = qs_ext;
      default:    offset_o = idx_val_i;
    endcase
  end
endmodule

// File: rtl/ls_ea_update_ctl.sv
module ls_ea_update_ctl #(
  parameter int REG_W = 5
) (
  input  logic             update_i,
  input  logic             is_store_i,
  input  logic [REG_W-1:0] ra_i,
  input  logic [REG_W-1:0] rt_i,
  output logic             base_zero_o,
  output logic             invalid_o,
  output logic             wb_en_o
);
  logic ra_is_zero, ra_eq_rt;

  assign ra_is_zero  = (ra_i == '0);
  assign ra_eq_rt    = (ra_i == rt_i);
  // update forms always read the real register
  assign base_zero_o = !update_i && ra_is_zero;
  assign invalid_o   = update_i && (ra_is_zero || (!is_store_i && ra_eq_rt));
  assign wb_en_o     = update_i && !invalid_o;

  always_comb begin
    if (update_i && ra_is_zero) a_r8_r9_zero_base_invalid: assert (invalid_o && !wb_en_o);
    if (!update_i) a_r10_no_update_quiet: assert (!wb_en_o && !invalid_o);
  end
endmodule

// File: rtl/ls_ea_unit.sv
module ls_ea_unit
  import ls_ea_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int REG_W = 5,
  parameter int IMM_W = 16,
  parameter int WS_W  = 14,
  parameter int QS_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       form_i,
  input  logic             update_i,
  input  logic             is_store_i,
  input  logic [REG_W-1:0] ra_i,
  input  logic [REG_W-1:0] rt_i,
  input  logic [XLEN-1:0]  ra_val_i,
  input  logic [XLEN-1:0]  rb_val_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic             valid_o,
  output logic [XLEN-1:0]  ea_o,
  output logic             wb_en_o,
  output logic [REG_W-1:0] wb_idx_o,
  output logic [XLEN-1:0]  wb_data_o,
  output logic             invalid_o
);
  logic [XLEN-1:0] offset, base, ea_d;
  logic            base_zero, inv_d, wb_d;

  ls_ea_offset #(.XLEN(XLEN), .IMM_W(IMM_W), .WS_W(WS_W), .QS_W(QS_W)) u_offset (
    .form_i    (ea_form_e'(form_i)),
    .imm_i     (imm_i),
    .idx_val_i (rb_val_i),
    .offset_o  (offset)
  );

  ls_ea_update_ctl #(.REG_W(REG_W)) u_upd (
    .update_i    (update_i),
    .is_store_i  (is_store_i),
    .ra_i        (ra_i),
    .rt_i        (rt_i),
    .base_zero_o (base_zero),
    .invalid_o   (inv_d),
    .wb_en_o     (wb_d)
  );

  assign base = base_zero ? '0 : ra_val_i;
  assign ea_d = base + offset;  // modulo 2^XLEN

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      ea_o      <= '0;
      wb_en_o   <= 1'b0;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o   <= valid_i;
      wb_en_o   <= valid_i && wb_d;
      invalid_o <= valid_i && inv_d;
      if (valid_i) begin
        ea_o      <= ea_d;
        wb_idx_o  <= ra_i;
        wb_data_o <= ea_d;
      end
    end
  end

  a_r10_wb_excludes_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_en_o && invalid_o));
  a_r12_wb_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o || invalid_o) |-> valid_o);
  a_r10_wb_data_is_ea: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (wb_data_o == ea_o));
  a_r12_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r12_ea_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(ea_o));
  a_r8_load_self_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && update_i && !is_store_i && ra_i == rt_i) |=> (invalid_o && !wb_en_o));
endmodule

// File: tb/ls_ea_unit_tb.sv
module ls_ea_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  form_i = '0;
  logic        update_i = 1'b0, is_store_i = 1'b0;
  logic [4:0]  ra_i = '0, rt_i = '0;
  logic [63:0] ra_val_i = '0, rb_val_i = '0;
  logic [15:0] imm_i = '0;
  logic        valid_o, wb_en_o, invalid_o;
  logic [63:0] ea_o, wb_data_o;
  logic [4:0]  wb_idx_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ls_ea_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .form_i(form_i),
    .update_i(update_i), .is_store_i(is_store_i), .ra_i(ra_i), .rt_i(rt_i),
    .ra_val_i(ra_val_i), .rb_val_i(rb_val_i), .imm_i(imm_i),
    .valid_o(valid_o), .ea_o(ea_o), .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o),
    .wb_data_o(wb_data_o), .invalid_o(invalid_o)
  );

  function automatic logic [63:0] ref_ea(logic [1:0] f, logic upd, logic [4:0] ra,
                                         logic [63:0] rav, logic [63:0] rbv, logic [15:0] im);
    logic [63:0] b, o;
    b = (upd || ra != 0) ? rav : 64'd0;
    case (f)
      2'd0: o = 64'($signed(im));
      2'd1: o = 64'($signed({im[13:0], 2'b00}));
      2'd2: o = 64'($signed({im[11:0], 4'b0000}));
      default: o = rbv;
    endcase
    return b + o;
  endfunction

  function automatic logic ref_inv(logic upd, logic st, logic [4:0] ra, logic [4:0] rt);
    if (!upd) return 1'b0;
    if (ra == 0) return 1'b1;
    return !st && (ra == rt);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(string tag, logic [1:0] f, logic upd, logic st, logic [4:0] ra,
                     logic [4:0] rt, logic [63:0] rav, logic [63:0] rbv, logic [15:0] im);
    logic [63:0] e;
    logic inv;
    @(negedge clk);
    valid_i = 1; form_i = f; update_i = upd; is_store_i = st; ra_i = ra; rt_i = rt;
    ra_val_i = rav; rb_val_i = rbv; imm_i = im;
    e   = ref_ea(f, upd, ra, rav, rbv, im);
    inv = ref_inv(upd, st, ra, rt);
    @(negedge clk);
    valid_i = 0;
    chk({tag, " R12 valid_o"}, 64'(valid_o), 64'd1);
    chk({tag, " ea"}, ea_o, e);
    chk({tag, " R8/R9 invalid"}, 64'(invalid_o), 64'(inv));
    chk({tag, " R10 wb_en"}, 64'(wb_en_o), 64'(upd && !inv));
    if (upd && !inv) begin
      chk({tag, " R10 wb_idx"}, 64'(wb_idx_o), 64'(ra));
      chk({tag, " R10 wb_data"}, wb_data_o, e);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] hold;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    chk("R1 reset valid_o", 64'(valid_o), 0);
    chk("R1 reset ea", ea_o, 0);
    chk("R1 reset wb_en", 64'(wb_en_o), 0);
    chk("R1 reset invalid", 64'(invalid_o), 0);
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    chk("R1 idle wb_data", wb_data_o, 0);
    chk("R1 idle wb_idx", 64'(wb_idx_o), 0);

    run("R2 disp neg", 2'd0, 0, 0, 5'd3, 5'd4, 64'h1000, 64'h0, 16'h8000);
    chk("R2 value", ea_o, 64'h1000 - 64'h8000);
    run("R3 ws min", 2'd1, 0, 0, 5'd3, 5'd4, 64'h10_0000, 0, 16'h2000);
    chk("R3 value", ea_o, 64'h10_0000 - 64'h8000);
    run("R3 ws max, upper bits ignored", 2'd1, 0, 0, 5'd3, 5'd4, 64'h0, 0, 16'hDFFF);
    chk("R3 value2", ea_o, 64'h7FFC);
    run("R4 qs min", 2'd2, 0, 0, 5'd3, 5'd4, 64'h10_0000, 0, 16'hF800);
    chk("R4 value", ea_o, 64'h10_0000 - 64'h8000);
    run("R4 qs max", 2'd2, 0, 1, 5'd3, 5'd4, 64'h0, 0, 16'h07FF);
    chk("R4 value2", ea_o, 64'h7FF0);
    run("R5 indexed", 2'd3, 0, 0, 5'd7, 5'd1, 64'h123, 64'h456, 16'hFFFF);
    chk("R5 value", ea_o, 64'h579);
    run("R6 ra zero base", 2'd3, 0, 0, 5'd0, 5'd1, 64'hDEAD_BEEF, 64'h40, 0);
    chk("R6 value", ea_o, 64'h40);
    run("R6 ra zero store", 2'd0, 0, 1, 5'd0, 5'd0, 64'hFFFF, 0, 16'h0010);
    run("R7 update real base", 2'd0, 1, 1, 5'd0, 5'd2, 64'h500, 0, 16'h0004);
    chk("R7 value", ea_o, 64'h504);
    run("R8 load ra0", 2'd0, 1, 0, 5'd0, 5'd9, 64'h80, 0, 16'h8);
    run("R8 load ra=rt", 2'd3, 1, 0, 5'd9, 5'd9, 64'h80, 64'h8, 0);
    run("R9 store ra0", 2'd3, 1, 1, 5'd0, 5'd9, 64'h80, 64'h8, 0);
    run("R9 store ra=rs", 2'd1, 1, 1, 5'd9, 5'd9, 64'h80, 0, 16'h0001);
    chk("R9 value", wb_data_o, 64'h84);
    run("R10 load update ok", 2'd2, 1, 0, 5'd31, 5'd1, 64'h1000, 0, 16'h0001);
    run("R11 wrap up", 2'd3, 0, 0, 5'd5, 5'd1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 0);
    chk("R11 value", ea_o, 64'h10);
    run("R11 wrap down", 2'd0, 1, 1, 5'd5, 5'd1, 64'h4, 0, 16'hFFF0);
    chk("R11 value2", ea_o, 64'hFFFF_FFFF_FFFF_FFF4);

    hold = ea_o;
    @(negedge clk);
    ra_val_i = 64'h9999; imm_i = 16'h1234; update_i = 1; ra_i = 5'd3;
    @(negedge clk);
    chk("R12 idle valid_o", 64'(valid_o), 0);
    chk("R12 idle wb_en", 64'(wb_en_o), 0);
    chk("R12 idle invalid", 64'(invalid_o), 0);
    chk("R12 idle ea hold", ea_o, hold);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 5 == 0) a = ~64'h0 - 64'($urandom_range(0, 64));
      run("rand R2-R11", 2'($urandom), 1'($urandom), 1'($urandom),
          5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), a, b, 16'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule